// File: doc/BRIEF.md
# Paged Address Translation Unit

This unit turns a virtual address from a processor into a physical address. The low offset bits are passed through unchanged, and the virtual page number is mapped to a physical page number. The mapping comes from a one-level page table kept in physical memory, which starts at an address held in a table-root register. A small fully associative translation cache holds recent mappings. On a hit the result is ready without any memory traffic. On a miss the unit fetches the table entry for that page through a request/acknowledge memory port. It then checks the entry and, if the entry passes, stores the mapping in the cache.

Each table entry has three fields: a residency flag, a two-bit rights code and a physical page number. If the page is not resident, the unit raises a page fault and gives no address. If the rights code does not allow the requested kind of access, the unit raises a protection fault. Software changes the active process by writing the table-root register. That write also empties the translation cache.

The unit handles one request at a time. With the default parameters, pages are 1 KB, there are 32 virtual and 8 physical pages, virtual addresses are 15 bits wide and physical addresses are 13 bits wide.

Top module: `page_xlate`

## Requirements
- R1: When `done` is high, `paddr` equals the physical page number followed by the low 10 offset bits of the accepted virtual address, copied unchanged.
- R2: On a cache miss, `mem_addr` equals the table root plus the virtual page number (bits 14:10). `mem_req` stays high until the cycle in which `mem_ack` is seen.
- R3: A table entry is decoded as follows: bit 0 is the residency flag, bits 2:1 are the rights code and bits 5:3 are the physical page number.
- R4: An entry whose bit 0 is 0 produces a one-cycle `page_fault`. During that cycle `paddr` is zero and `done` stays low.
- R5: Access kinds are encoded as 00 read, 01 write and 10 fetch. Rights codes are 00 read-only, 01 read/write, 10 execute and 11 reserved. A read is allowed on 00 or 01, a write only on 01, and a fetch only on 10. Access kind 11 and rights code 11 always fail. A failed check gives a one-cycle `prot_fault` with `paddr` zero. The rights check also applies to entries found in the cache.
- R6: A cache hit raises `done` two clock edges after the request is accepted, and no memory request is made.
- R7: Only entries that are resident and pass the rights check are written into the cache. Repeating a faulting access therefore fetches the entry from memory again.
- R8: A pulse on `root_we` loads `root_wdata` into the table root and invalidates every cache entry.
- R9: The cache holds 8 entries and refills them in round-robin order. The ninth distinct page loaded after a flush replaces the first page, and the other pages keep hitting.
- R10: Every accepted request produces exactly one of `done`, `page_fault` or `prot_fault`, held high for exactly one cycle.
- R11: If the table root is written while a request is in flight, that request still completes from the entry it fetched, but its mapping is not cached.
- R12: After reset, `ready` is high, and `done`, both fault outputs and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request strobe, taken only while `ready` is high |
| req_vaddr | input | 15 | Virtual address |
| req_kind | input | 2 | Access kind: 00 read, 01 write, 10 fetch |
| ready | output | 1 | Unit is idle and can accept a request |
| done | output | 1 | One-cycle success pulse |
| paddr | output | 13 | Physical address, valid while `done` is high, otherwise zero |
| page_fault | output | 1 | One-cycle pulse: the page is not resident |
| prot_fault | output | 1 | One-cycle pulse: the access is not allowed |
| root_we | input | 1 | Table-root write strobe |
| root_wdata | input | 16 | New table-root address |
| mem_req | output | 1 | Table-entry read request |
| mem_addr | output | 16 | Table-entry address |
| mem_ack | input | 1 | Memory acknowledge; `mem_rdata` is valid in the same cycle |
| mem_rdata | input | 6 | Table entry read from memory |

## Verification
A corrupted cache tag or page-number field shows up on the very next hit to that page as a wrong `paddr`, or as a memory request where none was expected. The bench therefore re-touches every page it has installed and checks both the address and the memory traffic count. A wrong round-robin pointer appears only after eight more installs, when a page that should still be cached triggers a table fetch. A flush that is missing or incomplete shows up on the first access after the root write: the stale mapping returns an address from the old table instead of causing a fetch from the new one.

// File: rtl/page_xlate.sv
module page_xlate #(
  parameter int OFF_W = 10,
  parameter int VPN_W = 5,
  parameter int PPN_W = 3,
  parameter int TLB_N = 8,
  parameter int MAW   = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [OFF_W+VPN_W-1:0]   req_vaddr,
  input  logic [1:0]               req_kind,
  output logic                     ready,
  output logic                     done,
  output logic [OFF_W+PPN_W-1:0]   paddr,
  output logic                     page_fault,
  output logic                     prot_fault,
  input  logic                     root_we,
  input  logic [MAW-1:0]           root_wdata,
  output logic                     mem_req,
  output logic [MAW-1:0]           mem_addr,
  input  logic                     mem_ack,
  input  logic [PPN_W+2:0]         mem_rdata
);
  localparam int VA_W  = OFF_W + VPN_W;
  localparam int PTE_W = PPN_W + 3;
  localparam int RR_W  = (TLB_N > 1) ? $clog2(TLB_N) : 1;

  typedef enum logic [2:0] {S_IDLE, S_LOOKUP, S_WREQ, S_WWAIT, S_DONE, S_FAULT} st_t;

  st_t              st;
  logic [VA_W-1:0]  va_q;
  logic [1:0]       kind_q;
  logic [MAW-1:0]   root_q, maddr_q;
  logic [PTE_W-1:0] pte_q;
  logic [PPN_W-1:0] ppn_q;
  logic             pf_q, stale_q;
  logic [RR_W-1:0]  rr_q;

  logic [TLB_N-1:0] tv;
  logic [VPN_W-1:0] tvpn [TLB_N];
  logic [PPN_W-1:0] tppn [TLB_N];
  logic [1:0]       trt  [TLB_N];

  function automatic logic allowed(input logic [1:0] rt, input logic [1:0] k);
    case (k)
      2'b00:   allowed = (rt == 2'b00) || (rt == 2'b01);
      2'b01:   allowed = (rt == 2'b01);
      2'b10:   allowed = (rt == 2'b10);
      default: allowed = 1'b0;
    endcase
  endfunction

  wire [VPN_W-1:0] vpn_q = va_q[VA_W-1:OFF_W];

  logic             hit;
  logic [PPN_W-1:0] hit_ppn;
  logic [1:0]       hit_rt;
  always_comb begin
    hit = 1'b0;
    hit_ppn = '0;
    hit_rt = '0;
    for (int i = 0; i < TLB_N; i++)
      if (tv[i] && tvpn[i] == vpn_q) begin
        hit = 1'b1;
        hit_ppn = tppn[i];
        hit_rt = trt[i];
      end
  end

  wire pte_ok  = pte_q[0] && allowed(pte_q[2:1], kind_q);
  wire install = (st == S_WWAIT) && pte_ok && !stale_q && !root_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      va_q <= '0;
      kind_q <= '0;
      maddr_q <= '0;
      pte_q <= '0;
      ppn_q <= '0;
      pf_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va_q <= req_vaddr;
          kind_q <= req_kind;
          st <= S_LOOKUP;
        end
        S_LOOKUP: if (hit) begin
          if (allowed(hit_rt, kind_q)) begin
            ppn_q <= hit_ppn;
            st <= S_DONE;
          end else begin
            pf_q <= 1'b0;
            st <= S_FAULT;
          end
        end else begin
          maddr_q <= root_q + {{(MAW-VPN_W){1'b0}}, vpn_q};
          st <= S_WREQ;
        end
        S_WREQ: if (mem_ack) begin
          pte_q <= mem_rdata;
          st <= S_WWAIT;
        end
        S_WWAIT: begin
          if (!pte_q[0]) begin
            pf_q <= 1'b1;
            st <= S_FAULT;
          end else if (!pte_ok) begin
            pf_q <= 1'b0;
            st <= S_FAULT;
          end else begin
            ppn_q <= pte_q[PTE_W-1:3];
            st <= S_DONE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      root_q <= '0;
      stale_q <= 1'b0;
    end else begin
      if (root_we) root_q <= root_wdata;
      if (root_we && st != S_IDLE) stale_q <= 1'b1;
      else if (st == S_IDLE) stale_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tv <= '0;
      rr_q <= '0;
    end else if (root_we) begin
      tv <= '0;
    end else if (install) begin
      tv[rr_q] <= 1'b1;
      rr_q <= (rr_q == RR_W'(TLB_N-1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (install) begin
      tvpn[rr_q] <= vpn_q;
      tppn[rr_q] <= pte_q[PTE_W-1:3];
      trt[rr_q]  <= pte_q[2:1];
    end
  end

  assign ready      = (st == S_IDLE);
  assign done       = (st == S_DONE);
  assign page_fault = (st == S_FAULT) && pf_q;
  assign prot_fault = (st == S_FAULT) && !pf_q;
  assign paddr      = done ? {ppn_q, va_q[OFF_W-1:0]} : '0;
  assign mem_req    = (st == S_WREQ);
  assign mem_addr   = maddr_q;
endmodule

// File: rtl/page_xlate_chk.sv
module page_xlate_chk #(
  parameter int OFF_W = 10,
  parameter int VPN_W = 5,
  parameter int PPN_W = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic [OFF_W+VPN_W-1:0] req_vaddr,
  input logic                   ready,
  input logic                   done,
  input logic                   page_fault,
  input logic                   prot_fault,
  input logic [OFF_W+PPN_W-1:0] paddr,
  input logic                   mem_req,
  input logic                   mem_ack
);
  logic [OFF_W-1:0] off_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) off_q <= '0;
    else if (req_valid && ready) off_q <= req_vaddr[OFF_W-1:0];

  wire any_res = done || page_fault || prot_fault;

  p_one_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, page_fault, prot_fault}));
  p_result_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    any_res |=> !any_res);
  p_offset_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> paddr[OFF_W-1:0] == off_q);
  p_no_addr_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (page_fault || prot_fault) |-> paddr == '0);
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req);
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !(mem_req || any_res));
endmodule

bind page_xlate page_xlate_chk #(.OFF_W(OFF_W), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
  .ready(ready), .done(done), .page_fault(page_fault), .prot_fault(prot_fault),
  .paddr(paddr), .mem_req(mem_req), .mem_ack(mem_ack)
);

// File: tb/sim_page_xlate.sv
module sim_page_xlate;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [14:0] req_vaddr = '0;
  logic [1:0] req_kind = '0;
  logic ready, done, page_fault, prot_fault, mem_req;
  logic [12:0] paddr;
  logic root_we = 0;
  logic [15:0] root_wdata = '0;
  logic [15:0] mem_addr;
  logic mem_ack = 0;
  logic [5:0] mem_rdata = '0;

  always #10 clk = ~clk;

  page_xlate u0 (.*);

  int checks = 0, fails = 0, cyc = 0, walks = 0, mdly = 0, res_cyc = 0;
  logic [15:0] last_waddr = '0;
  logic [5:0] ptmem [0:1023];
  int q_kind[$];
  logic [12:0] q_pa[$];
  string q_tag[$];

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [5:0] mkpte(input logic [2:0] p, input logic [1:0] rt, input logic v);
    return {p, rt, v};
  endfunction

  // memory model: acknowledges on the third low phase of a request
  always @(negedge clk) begin
    if (mem_ack) mem_ack = 0;
    else if (mem_req) begin
      if (mdly == 2) begin
        mdly = 0;
        mem_ack = 1;
        mem_rdata = ptmem[mem_addr[9:0]];
        last_waddr = mem_addr;
        walks++;
      end else mdly++;
    end
  end

  // monitor: pops the scoreboard on every result
  always @(negedge clk) begin
    if (done || page_fault || prot_fault) begin
      int k;
      k = done ? 0 : (page_fault ? 1 : 2);
      res_cyc = cyc;
      if (q_kind.size() == 0) chk(0, "R10", "unexpected result", k, 9);
      else begin
        int ek;
        logic [12:0] ep;
        string t;
        ek = q_kind.pop_front(); ep = q_pa.pop_front(); t = q_tag.pop_front();
        chk(k == ek, t, "result kind", k, ek);
        chk(paddr == ep, t, "paddr", paddr, ep);
      end
    end
  end

  task automatic set_root(input logic [15:0] r);
    @(negedge clk);
    root_we = 1; root_wdata = r;
    @(negedge clk);
    root_we = 0;
  endtask

  // ek: 0 done, 1 page fault, 2 protection fault; ptea: entry that defines the result
  task automatic xlate(input logic [14:0] va, input logic [1:0] k, input int ek,
                       input bit ewalk, input logic [15:0] ptea, input string tag);
    int w0, c0, n;
    logic [5:0] pte;
    pte = ptmem[ptea[9:0]];
    q_kind.push_back(ek);
    q_pa.push_back(ek == 0 ? {pte[5:3], va[9:0]} : 13'h0);
    q_tag.push_back(tag);
    @(negedge clk);
    while (!ready) @(negedge clk);
    w0 = walks; c0 = cyc;
    req_valid = 1; req_vaddr = va; req_kind = k;
    @(negedge clk);
    req_valid = 0;
    n = 0;
    while (q_kind.size() != 0 && n < 200) begin @(negedge clk); n++; end
    chk(n < 200, tag, "result timeout", n, 0);
    chk((walks - w0) == int'(ewalk), tag, "table fetches", walks - w0, int'(ewalk));
    if (ewalk) chk(last_waddr == ptea, tag, "entry address (R2)", last_waddr, ptea);
    else chk(res_cyc - c0 == 2, tag, "hit latency (R6)", res_cyc - c0, 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired (R10)");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int v = 0; v < 32; v++) begin
      ptmem[16'h100 + v] = mkpte(v[2:0], 2'b01, 1'b1);
      ptmem[16'h200 + v] = mkpte(~v[2:0], 2'b01, 1'b1);
    end
    ptmem[16'h105] = mkpte(3'd0, 2'b01, 1'b0);
    ptmem[16'h106] = mkpte(3'd6, 2'b00, 1'b1);
    ptmem[16'h107] = mkpte(3'd2, 2'b10, 1'b1);
    ptmem[16'h108] = mkpte(3'd3, 2'b11, 1'b1);

    repeat (3) @(negedge clk);
    chk(ready == 1, "R12", "ready after reset", ready, 1);
    chk({done, page_fault, prot_fault, mem_req} == 4'b0, "R12", "outputs after reset",
        {done, page_fault, prot_fault, mem_req}, 0);
    rst_n = 1;
    set_root(16'h100);

    xlate({5'd1, 10'h2AB}, 2'b00, 0, 1, 16'h101, "R1 R3 miss read");
    xlate({5'd1, 10'h015}, 2'b00, 0, 0, 16'h101, "R6 hit read");
    xlate({5'd1, 10'h3FF}, 2'b01, 0, 0, 16'h101, "R5 hit write rw");
    xlate({5'd5, 10'h000}, 2'b00, 1, 1, 16'h105, "R4 not resident");
    xlate({5'd5, 10'h000}, 2'b00, 1, 1, 16'h105, "R7 fault refetch");
    xlate({5'd6, 10'h120}, 2'b00, 0, 1, 16'h106, "R5 read ro");
    xlate({5'd6, 10'h120}, 2'b01, 2, 0, 16'h106, "R5 write ro hit");
    xlate({5'd6, 10'h120}, 2'b10, 2, 0, 16'h106, "R5 fetch ro hit");
    xlate({5'd7, 10'h044}, 2'b10, 0, 1, 16'h107, "R5 fetch exec");
    xlate({5'd7, 10'h044}, 2'b00, 2, 0, 16'h107, "R5 read exec hit");
    xlate({5'd8, 10'h001}, 2'b00, 2, 1, 16'h108, "R5 reserved rights");
    xlate({5'd8, 10'h001}, 2'b00, 2, 1, 16'h108, "R7 reserved refetch");
    xlate({5'd2, 10'h155}, 2'b10, 2, 1, 16'h102, "R5 fetch rw");
    xlate({5'd2, 10'h155}, 2'b00, 0, 1, 16'h102, "R7 not cached after fault");
    xlate({5'd2, 10'h155}, 2'b11, 2, 0, 16'h102, "R5 kind 11");

    set_root(16'h100);
    xlate({5'd1, 10'h0AA}, 2'b00, 0, 1, 16'h101, "R8 flush refetch");
    for (int v = 9; v <= 16; v++)
      xlate({v[4:0], 10'h033}, 2'b00, 0, 1, 16'h100 + 16'(v), "R9 fill");
    xlate({5'd9, 10'h2F0}, 2'b00, 0, 0, 16'h109, "R9 second kept");
    xlate({5'd16, 10'h001}, 2'b01, 0, 0, 16'h110, "R9 newest kept");
    xlate({5'd1, 10'h0AA}, 2'b00, 0, 1, 16'h101, "R9 oldest replaced");

    set_root(16'h200);
    xlate({5'd3, 10'h3C3}, 2'b00, 0, 1, 16'h203, "R8 new table");
    fork
      xlate({5'd4, 10'h111}, 2'b00, 0, 1, 16'h204, "R11 root write mid walk");
      begin
        wait (mem_req);
        @(negedge clk);
        root_we = 1; root_wdata = 16'h100;
        @(negedge clk);
        root_we = 0;
      end
    join
    xlate({5'd4, 10'h111}, 2'b00, 0, 1, 16'h104, "R11 stale not cached");
    xlate({5'd4, 10'h222}, 2'b01, 0, 0, 16'h104, "R11 fresh cached");

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule